// File: doc/BRIEF.md
# Resizable Circular Reorder Buffer

This block is an in-order retirement queue whose usable depth can change while it runs. Storage is split into equal partitions, and only a contiguous run of them starting at index zero is in use. The upper edge of that run is the wrap point. A tail pointer hands out slots to dispatched instructions and wraps to zero at the wrap point. A head pointer retires finished entries in program order. Results come back out of order, addressed by slot index.

A request to add or remove one partition does not take effect at once. The block records a pending target bound one partition above or below the current one. It moves that bound into place only when the live entries sit where the circular order survives the change. Adding waits until the live region does not wrap. Removing waits until no live entry and no tail position lies in the departing partition. While a removal waits, dispatch into the departing partition is refused. A flush empties the queue and applies any pending change in the same cycle.

The controller has three states. RS_IDLE has nothing pending. RS_GROW_WAIT waits to add a partition. RS_SHRINK_WAIT waits to remove one. A request taken in RS_IDLE moves to the matching wait state. A wait state goes back to RS_IDLE when its safety condition holds, and it then commits the new partition count. A flush also sends a wait state back to RS_IDLE and commits the new count.

Top module: `rob_resizable`

## Requirements
- R1: After reset the queue is empty, every partition is in use, no resize is pending, and the dispatch slot index is 0.
- R2: An accepted dispatch stores its payload at the slot shown on `disp_idx`, and that index then advances by one. The index goes back to 0 when it reaches partitions-in-use times entries-per-partition. `disp_ready` is low when the occupancy equals that capacity.
- R3: `commit_valid` is high only when the queue is not empty and the head slot has received a writeback. It then presents that slot's dispatch payload and its latest written result. A commit taken with `commit_take` advances the head in dispatch order, with the same wrap rule as the tail.
- R4: `occupancy` equals accepted dispatches minus taken commits since the last reset or flush.
- R5: In RS_IDLE, `grow_req` moves the block to RS_GROW_WAIT when fewer than all partitions are in use. `resize_pending` then rises on the next cycle.
- R6: In RS_GROW_WAIT, one partition is added when the queue is empty or the head index is below the tail index. Otherwise the add waits, which in practice means until the head has wrapped back to zero.
- R7: In RS_SHRINK_WAIT, the top partition is removed when the queue is empty, or when the head index is below the tail index and the tail index is at most the new bound. At that point a pointer equal to or above the new bound becomes 0.
- R8: In RS_SHRINK_WAIT, `disp_ready` is low while the tail index is at or above the new bound, so no entry is placed in the departing partition.
- R9: A request is ignored when it would go beyond all partitions or below the minimum count, while a change is pending, or in a flush cycle. If both requests arrive together, growth wins.
- R10: A flush ignores dispatch, writeback and commit in that cycle. It empties the queue, sets both pointers to 0, and completes any pending change at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_payload | input | PAY_W | Data stored with a dispatched entry |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_idx | output | IDX_W | Slot the next dispatch will occupy |
| wb_valid | input | 1 | Result writeback strobe |
| wb_idx | input | IDX_W | Slot receiving the result |
| wb_data | input | PAY_W | Result value |
| commit_valid | output | 1 | Head entry is finished and may retire |
| commit_take | input | 1 | Retire the head entry |
| commit_payload | output | PAY_W | Dispatch payload of the head entry |
| commit_result | output | PAY_W | Result of the head entry |
| flush | input | 1 | Discard all entries |
| grow_req | input | 1 | Ask for one more partition |
| shrink_req | input | 1 | Ask for one fewer partition |
| cur_parts | output | PW | Partitions now in use |
| occupancy | output | CNT_W | Live entry count |
| resize_pending | output | 1 | An add or remove is waiting |

## Verification
The bench builds the block with four entries per partition, four partitions and a minimum of one. With these values the tail and head wrap every few cycles at any size. Resize requests therefore land often on wrapped regions, on a tail inside the departing partition, and on a full or empty queue. The slot count stays at sixteen, so the reference model steps through every size from one to four partitions many times within a few thousand cycles. Traffic windows with different dispatch, commit and flush rates push the queue through the deferred-add and deferred-remove paths, including a head that wraps before a removal can finish.

// File: rtl/rob_rsz_pkg.sv
package rob_rsz_pkg;

    typedef enum logic [1:0] {
        RS_IDLE        = 2'd0,
        RS_GROW_WAIT   = 2'd1,
        RS_SHRINK_WAIT = 2'd2
    } rsz_state_e;

endpackage

// File: rtl/rob_rsz_ctrl.sv
module rob_rsz_ctrl
    import rob_rsz_pkg::*;
#(
    parameter int PART_ENTRIES = 16,
    parameter int NUM_PARTS    = 4,
    parameter int MIN_PARTS    = 1,
    localparam int DEPTH = NUM_PARTS * PART_ENTRIES,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PW    = $clog2(NUM_PARTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grow_req,
    input  logic             shrink_req,
    input  logic             flush,
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] tail,
    input  logic [CNT_W-1:0] count,
    output logic [PW-1:0]    cur_parts,
    output logic             pending,
    output logic             shrinking,
    output logic [CNT_W-1:0] cap,
    output logic [CNT_W-1:0] new_bound,
    output logic [CNT_W-1:0] eff_bound,
    output logic             disp_block
);

    localparam logic [CNT_W-1:0] PE    = CNT_W'(PART_ENTRIES);
    localparam logic [PW-1:0]    P_MAX = PW'(NUM_PARTS);
    localparam logic [PW-1:0]    P_MIN = PW'(MIN_PARTS);

    rsz_state_e       state_q, state_n;
    logic [PW-1:0]    parts_q, parts_n;
    logic [PW-1:0]    target_parts;
    logic [CNT_W-1:0] tail_e;
    logic             no_wrap;
    logic             grow_safe;
    logic             shrink_safe;
    logic             apply;

    // Geometry of the current and target bounds
    always_comb begin
        target_parts = (state_q == RS_GROW_WAIT) ? parts_q + PW'(1) : parts_q - PW'(1);
        cap          = CNT_W'(parts_q) * PE;
        new_bound    = CNT_W'(target_parts) * PE;
        tail_e       = CNT_W'(tail);
        no_wrap      = (count == '0) || (head < tail);
        grow_safe    = no_wrap;
        shrink_safe  = (count == '0) || ((head < tail) && (tail_e <= new_bound));
        apply        = !flush &&
                       (((state_q == RS_GROW_WAIT) && grow_safe) ||
                        ((state_q == RS_SHRINK_WAIT) && shrink_safe));
        eff_bound    = apply ? new_bound : cap;
    end

    // Next state and partition count
    always_comb begin
        state_n = state_q;
        parts_n = parts_q;
        unique case (state_q)
            RS_IDLE: begin
                if (!flush) begin
                    if (grow_req && (parts_q < P_MAX)) begin
                        state_n = RS_GROW_WAIT;
                    end else if (shrink_req && (parts_q > P_MIN)) begin
                        state_n = RS_SHRINK_WAIT;
                    end
                end
            end
            RS_GROW_WAIT, RS_SHRINK_WAIT: begin
                if (flush || apply) begin
                    state_n = RS_IDLE;
                    parts_n = target_parts;
                end
            end
            default: begin
                state_n = RS_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            parts_q <= P_MAX;
        end else begin
            state_q <= state_n;
            parts_q <= parts_n;
        end
    end

    // Outputs
    always_comb begin
        cur_parts  = parts_q;
        pending    = (state_q != RS_IDLE);
        shrinking  = (state_q == RS_SHRINK_WAIT);
        disp_block = shrinking && (tail_e >= new_bound);
    end

    AST_PARTS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (parts_q >= P_MIN) && (parts_q <= P_MAX)); // R9

    AST_PARTS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (parts_q != $past(parts_q)) |->
            ((parts_q == $past(parts_q) + PW'(1)) || (parts_q == $past(parts_q) - PW'(1)))); // R6

    AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && flush) |=> !pending); // R10

endmodule

// File: rtl/rob_ptr_unit.sv
module rob_ptr_unit #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_fire,
    input  logic             com_fire,
    input  logic             flush,
    input  logic [CNT_W-1:0] eff_bound,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] tail_adv, head_adv;
    logic [IDX_W-1:0] tail_n, head_n;
    logic [CNT_W-1:0] count_n;

    always_comb begin
        tail_adv = CNT_W'(tail) + CNT_W'(disp_fire);
        head_adv = CNT_W'(head) + CNT_W'(com_fire);
        tail_n   = (tail_adv >= eff_bound) ? '0 : IDX_W'(tail_adv);
        head_n   = (head_adv >= eff_bound) ? '0 : IDX_W'(head_adv);
        count_n  = count + CNT_W'(disp_fire) - CNT_W'(com_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head_n;
            tail  <= tail_n;
            count <= count_n;
        end
    end

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R4

    AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !com_fire); // R3

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
    parameter int DEPTH = 64,
    parameter int PAY_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_fire,
    input  logic [IDX_W-1:0] tail,
    input  logic [PAY_W-1:0] disp_payload,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [PAY_W-1:0] wb_data,
    input  logic [IDX_W-1:0] head,
    output logic             head_done,
    output logic [PAY_W-1:0] head_payload,
    output logic [PAY_W-1:0] head_result
);

    logic [PAY_W-1:0] pay_mem [DEPTH];
    logic [PAY_W-1:0] res_mem [DEPTH];
    logic [DEPTH-1:0] done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            if (disp_fire) done_q[tail] <= 1'b0;
            if (wb_en)     done_q[wb_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (disp_fire) pay_mem[tail] <= disp_payload;
        if (wb_en)     res_mem[wb_idx] <= wb_data;
    end

    always_comb begin
        head_done    = done_q[head];
        head_payload = pay_mem[head];
        head_result  = res_mem[head];
    end

endmodule

// File: rtl/rob_resizable.sv
module rob_resizable #(
    parameter int PART_ENTRIES = 16,
    parameter int NUM_PARTS    = 4,
    parameter int MIN_PARTS    = 1,
    parameter int PAY_W        = 8,
    localparam int DEPTH = NUM_PARTS * PART_ENTRIES,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PW    = $clog2(NUM_PARTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [PAY_W-1:0] disp_payload,
    output logic             disp_ready,
    output logic [IDX_W-1:0] disp_idx,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [PAY_W-1:0] wb_data,
    output logic             commit_valid,
    input  logic             commit_take,
    output logic [PAY_W-1:0] commit_payload,
    output logic [PAY_W-1:0] commit_result,
    input  logic             flush,
    input  logic             grow_req,
    input  logic             shrink_req,
    output logic [PW-1:0]    cur_parts,
    output logic [CNT_W-1:0] occupancy,
    output logic             resize_pending
);

    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count, cap, new_bound, eff_bound;
    logic             disp_block, shrinking, head_done;
    logic             disp_fire, com_fire, wb_en;

    always_comb begin
        disp_ready   = (count < cap) && !disp_block;
        disp_fire    = disp_valid && disp_ready && !flush;
        commit_valid = (count != '0) && head_done;
        com_fire     = commit_valid && commit_take && !flush;
        wb_en        = wb_valid && !flush;
        disp_idx     = tail;
        occupancy    = count;
    end

    rob_rsz_ctrl #(
        .PART_ENTRIES (PART_ENTRIES),
        .NUM_PARTS    (NUM_PARTS),
        .MIN_PARTS    (MIN_PARTS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grow_req   (grow_req),
        .shrink_req (shrink_req),
        .flush      (flush),
        .head       (head),
        .tail       (tail),
        .count      (count),
        .cur_parts  (cur_parts),
        .pending    (resize_pending),
        .shrinking  (shrinking),
        .cap        (cap),
        .new_bound  (new_bound),
        .eff_bound  (eff_bound),
        .disp_block (disp_block)
    );

    rob_ptr_unit #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .disp_fire (disp_fire),
        .com_fire  (com_fire),
        .flush     (flush),
        .eff_bound (eff_bound),
        .head      (head),
        .tail      (tail),
        .count     (count)
    );

    rob_entry_store #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_fire    (disp_fire),
        .tail         (tail),
        .disp_payload (disp_payload),
        .wb_en        (wb_en),
        .wb_idx       (wb_idx),
        .wb_data      (wb_data),
        .head         (head),
        .head_done    (head_done),
        .head_payload (commit_payload),
        .head_result  (commit_result)
    );

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy >= cap) |-> !disp_ready); // R2

    AST_NO_DISP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (shrinking && disp_fire) |-> (CNT_W'(disp_idx) < new_bound)); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((occupancy == '0) && (disp_idx == '0))); // R10

    AST_TAIL_IN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!resize_pending) |-> (CNT_W'(disp_idx) < cap)); // R2

endmodule

// File: tb/rob_resizable_test.sv
`timescale 1ns/1ps
module rob_resizable_test;

    localparam int PE    = 4;
    localparam int NP    = 4;
    localparam int MINP  = 1;
    localparam int PAY_W = 8;
    localparam int DEPTH = NP * PE;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PW    = $clog2(NP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [PAY_W-1:0] disp_payload = '0;
    logic disp_ready;
    logic [IDX_W-1:0] disp_idx;
    logic wb_valid = 1'b0;
    logic [IDX_W-1:0] wb_idx = '0;
    logic [PAY_W-1:0] wb_data = '0;
    logic commit_valid;
    logic commit_take = 1'b0;
    logic [PAY_W-1:0] commit_payload, commit_result;
    logic flush = 1'b0;
    logic grow_req = 1'b0;
    logic shrink_req = 1'b0;
    logic [PW-1:0] cur_parts;
    logic [CNT_W-1:0] occupancy;
    logic resize_pending;

    always #2 clk = ~clk;

    rob_resizable #(.PART_ENTRIES(PE), .NUM_PARTS(NP), .MIN_PARTS(MINP), .PAY_W(PAY_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_payload(disp_payload), .disp_ready(disp_ready), .disp_idx(disp_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .commit_valid(commit_valid), .commit_take(commit_take),
        .commit_payload(commit_payload), .commit_result(commit_result),
        .flush(flush), .grow_req(grow_req), .shrink_req(shrink_req),
        .cur_parts(cur_parts), .occupancy(occupancy), .resize_pending(resize_pending)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state: 0 idle, 1 adding, 2 removing
    int m_head, m_tail, m_cnt, m_parts, m_state;
    int m_pay [DEPTH];
    int m_res [DEPTH];
    bit m_done [DEPTH];
    bit last_flush;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int cs, ns;
        bit rdy, cv;
        cs  = m_parts * PE;
        ns  = (m_state == 1) ? cs + PE : cs - PE;
        rdy = (m_cnt < cs) && !(m_state == 2 && m_tail >= ns);
        cv  = (m_cnt > 0) && m_done[m_head];
        chk(last_flush ? "R10 disp_idx" : "R2 disp_idx", int'(disp_idx), m_tail);
        chk((m_state == 2) ? "R8 disp_ready" : "R2 disp_ready", int'(disp_ready), int'(rdy));
        chk(last_flush ? "R10 occupancy" : "R4 occupancy", int'(occupancy), m_cnt);
        chk((m_state == 2) ? "R7 cur_parts" : "R6 cur_parts", int'(cur_parts), m_parts);
        chk((m_state == 0) ? "R9 resize_pending" : "R5 resize_pending", int'(resize_pending), int'(m_state != 0));
        chk("R3 commit_valid", int'(commit_valid), int'(cv));
        if (cv) begin
            chk("R3 commit_payload", int'(commit_payload), m_pay[m_head]);
            chk("R3 commit_result", int'(commit_result), m_res[m_head]);
        end
    endtask

    task automatic step(input int p_disp, input int p_take, input int p_wb,
                        input int p_grow, input int p_shrink, input int p_flush);
        int cs, ns, bound, t, h, wi, np;
        bit rdy, dfire, cv, cfire, apply, fl;
        @(negedge clk);
        compare_all();
        disp_valid   = ($urandom_range(99) < p_disp);
        disp_payload = PAY_W'($urandom);
        commit_take  = ($urandom_range(99) < p_take);
        flush        = ($urandom_range(999) < p_flush);
        grow_req     = ($urandom_range(99) < p_grow);
        shrink_req   = ($urandom_range(99) < p_shrink);
        cs = m_parts * PE;
        wb_valid = 1'b0;
        wi = 0;
        if (m_cnt > 0 && $urandom_range(99) < p_wb) begin
            wi = m_head;
            for (int k = 0; k < int'($urandom_range(m_cnt - 1)); k++) wi = (wi + 1 == cs) ? 0 : wi + 1;
            wb_valid = 1'b1;
        end
        wb_idx  = IDX_W'(wi);
        wb_data = PAY_W'($urandom);
        // model next state
        fl    = flush;
        ns    = (m_state == 1) ? cs + PE : cs - PE;
        np    = (m_state == 1) ? m_parts + 1 : m_parts - 1;
        rdy   = (m_cnt < cs) && !(m_state == 2 && m_tail >= ns);
        dfire = disp_valid && rdy && !fl;
        cv    = (m_cnt > 0) && m_done[m_head];
        cfire = cv && commit_take && !fl;
        if (wb_valid && !fl) begin
            m_done[wi] = 1'b1;
            m_res[wi]  = int'(wb_data);
        end
        last_flush = fl;
        if (fl) begin
            if (m_state != 0) m_parts = np;
            m_state = 0;
            m_head = 0; m_tail = 0; m_cnt = 0;
        end else begin
            apply = (m_state == 1 && (m_cnt == 0 || m_head < m_tail)) ||
                    (m_state == 2 && (m_cnt == 0 || (m_head < m_tail && m_tail <= ns)));
            bound = apply ? ns : cs;
            t = m_tail;
            if (dfire) begin
                m_pay[t] = int'(disp_payload);
                m_done[t] = 1'b0;
                t++;
            end
            h = m_head + (cfire ? 1 : 0);
            m_tail = (t >= bound) ? 0 : t;
            m_head = (h >= bound) ? 0 : h;
            m_cnt = m_cnt + (dfire ? 1 : 0) - (cfire ? 1 : 0);
            if (apply) begin
                m_parts = np;
                m_state = 0;
            end else if (m_state == 0) begin
                if (grow_req && m_parts < NP) m_state = 1;
                else if (shrink_req && m_parts > MINP) m_state = 2;
            end
        end
    endtask

    initial begin
        m_head = 0; m_tail = 0; m_cnt = 0; m_parts = NP; m_state = 0; last_flush = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_pay[i] = 0; m_res[i] = 0; m_done[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 cur_parts", int'(cur_parts), NP);
        chk("R1 resize_pending", int'(resize_pending), 0);
        chk("R1 disp_idx", int'(disp_idx), 0);
        chk("R1 commit_valid", int'(commit_valid), 0);
        // fill to capacity, no commits (R2 full)
        repeat (DEPTH + 4) step(100, 0, 0, 0, 0, 0);
        // finish and drain
        repeat (60) step(0, 100, 80, 0, 0, 0);
        // mixed windows
        for (int w = 0; w < 12; w++) begin
            case (w % 6)
                0: repeat (400) step(80, 30, 60, 2, 2, 0);
                1: repeat (400) step(50, 70, 70, 5, 0, 0);
                2: repeat (400) step(70, 60, 60, 0, 6, 0);
                3: repeat (400) step(60, 50, 50, 4, 4, 8);
                4: repeat (400) step(90, 90, 90, 3, 3, 0);
                default: repeat (400) step(40, 40, 40, 8, 8, 20);
            endcase
        end
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule